// File: doc/BRIEF.md
# Configurable Serial Shift Unit

This block is a byte-wide synchronous serial transceiver for the peripheral side of a small controller. Software sets one 8-bit mode register and, by setting its go bit, starts one exchange. The unit shifts the transmit byte out on `sdo` and the byte on `sdi` in, one bit at a time. Bit order, clock idle level and sampling edge are all selectable. As master, the unit makes the serial clock from the core clock through a selectable divider. As slave, it follows a serial clock from outside, which it brings into the core clock domain and checks for edges.

At the end of the byte the unit waits about half a serial clock period and then finishes in a single cycle. In that cycle it clears the go bit, sets a sticky completion flag and moves the received byte into the data register. The flag also serves as status when interrupts are off. The interrupt output is the flag gated by a separate enable bit. Pad open-drain control, pin muxing and interrupt vectoring are left to the surrounding logic.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset the mode register, data register, interrupt enable and flag all read 0, `irq` is 0, and both `sck_oe` and `sdo_oe` are 0.
- R2: The mode register is read back as written. Its bit layout is [7] unit enable, [6] go, [5:4] rate code, [3] LSB-first, [2] external clock (slave), [1] clock idle level (CPOL), [0] sample phase (CPHA). A write can set go only when the same write sets the enable bit.
- R3: In master mode the serial clock changes level once every N core cycles. N is 1 for rate code 00, 32 for 01, 16 for 10 and 8 for 11.
- R4: A master transfer makes exactly 8 clock pulses (16 level changes). Afterwards the clock rests at the CPOL level.
- R5: With LSB-first at 0, bit 7 is sent and received first. With LSB-first at 1, bit 0 is sent and received first.
- R6: With CPHA=0, the first bit is on `sdo` before the first clock edge, and input is sampled on the first edge of each pulse. With CPHA=1, output changes on the first edge of each pulse and input is sampled on the second edge.
- R7: In slave mode the unit shifts on edges of `sck_in`, ignores the rate code, and keeps `sck_oe` at 0. `sck_in` must toggle no faster than once per 4 core cycles.
- R8: The go bit clears and the flag sets in the same cycle. That cycle comes about half a serial clock period after the last clock edge, and never in the cycle that follows that edge.
- R9: The flag stays set until `flag_clr` is pulsed. If a completion and a clear fall in the same cycle, the completion wins.
- R10: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R11: A data-register write during a transfer is ignored. The data register keeps its previous contents until the transfer completes, and then holds the received byte.
- R12: While the enable bit is 0, `sck_oe` and `sdo_oe` are 0 and `sck_out` and `sdo` are 0.
- R13: A mode-register write during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write value |
| cfg_rdata | output | 8 | Mode register contents |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Data register: transmit byte, then received byte |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | Interrupt enable write value |
| ien_q | output | 1 | Interrupt enable bit |
| flag_clr | input | 1 | Clears the completion flag |
| flag_q | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pin |

## Verification
A wrong edge count shows first on `sck_out`: a master transfer then has the wrong number of pulses, or the clock does not return to its idle level. The go bit also clears at the wrong time, within one serial clock period of the fault. A divider fault shows in the spacing between the first two clock edges. A tail-delay fault shows as the flag rising in the cycle right after the last edge, or far too late. Bit-order or phase faults in the shift registers show in the byte the bench's partner device captures from `sdo`, and in the received byte once go clears. A mode or data register that accepts writes while busy changes `cfg_rdata` or `dat_rdata` in the cycle after the write.

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int GAP_W    = 12,
  parameter int SLOW_DIV = 32,
  parameter int MID_DIV  = 16,
  parameter int FAST_DIV = 8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  input  logic       ien_we,
  input  logic       ien_wdata,
  output logic       ien_q,
  input  logic       flag_clr,
  output logic       flag_q,
  output logic       irq,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe
);
  localparam int NB    = 8;
  localparam int EDGES = 2 * NB;
  localparam int EW    = $clog2(EDGES);
  localparam int DW    = $clog2(SLOW_DIV);

  logic [7:0]       mode_q, buf_q, txs_q, rxs_q;
  logic [DW-1:0]    div_q, div_last;
  logic [EW-1:0]    ecnt_q;
  logic [GAP_W-1:0] since_q, gap_q;
  logic [2:0]       sck_sy;
  logic [1:0]       sdi_sy;
  logic             sck_lvl, tail_q;

  wire en   = mode_q[7];
  wire busy = mode_q[6];
  wire lsbf = mode_q[3];
  wire ext  = mode_q[2];
  wire cpol = mode_q[1];
  wire cpha = mode_q[0];

  wire start = cfg_we && !busy && cfg_wdata[7] && cfg_wdata[6];

  assign div_last = (mode_q[5:4] == 2'b00) ? '0 :
                    (mode_q[5:4] == 2'b01) ? DW'(SLOW_DIV - 1) :
                    (mode_q[5:4] == 2'b10) ? DW'(MID_DIV - 1) :
                                             DW'(FAST_DIV - 1);

  wire tick_m    = busy && !tail_q && !ext && (div_q == div_last);
  wire edge_s    = busy && !tail_q && ext && (sck_sy[2] ^ sck_sy[1]);
  wire ev        = tick_m || edge_s;
  wire leading   = !ecnt_q[0];
  wire last_edge = (ecnt_q == EW'(EDGES - 1));
  wire sample_ev = ev && (leading != cpha);
  wire shift_tx  = ev && (leading == cpha) && (ecnt_q != '0) && !last_edge;
  wire samp_bit  = ext ? sdi_sy[1] : sdi;
  wire done      = tail_q && (since_q == gap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (cfg_we && !busy) begin
      mode_q <= {cfg_wdata[7], cfg_wdata[7] & cfg_wdata[6], cfg_wdata[5:0]};
    end else if (done) begin
      mode_q[6] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (done) buf_q <= rxs_q;
      else if (dat_we && !busy) buf_q <= dat_wdata;
      if (ien_we) ien_q <= ien_wdata;
      if (done) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (start || !busy || div_q == div_last) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      sdi_sy <= {sdi_sy[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q   <= '0;
      rxs_q   <= '0;
      ecnt_q  <= '0;
      sck_lvl <= 1'b0;
    end else begin
      if (start) txs_q <= buf_q;
      else if (shift_tx) txs_q <= lsbf ? {1'b0, txs_q[7:1]} : {txs_q[6:0], 1'b0};
      if (sample_ev) rxs_q <= lsbf ? {samp_bit, rxs_q[7:1]} : {rxs_q[6:0], samp_bit};
      if (start) ecnt_q <= '0;
      else if (ev) ecnt_q <= ecnt_q + 1'b1;
      if (start) sck_lvl <= cfg_wdata[1];
      else if (tick_m) sck_lvl <= !sck_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      gap_q   <= '0;
      tail_q  <= 1'b0;
    end else begin
      if (start || ev) since_q <= '0;
      else if (since_q != '1) since_q <= since_q + 1'b1;
      if (ev && last_edge) gap_q <= since_q;
      if (start || done) tail_q <= 1'b0;
      else if (ev && last_edge) tail_q <= 1'b1;
    end
  end

  assign cfg_rdata = mode_q;
  assign dat_rdata = buf_q;
  assign irq       = flag_q & ien_q;
  assign sck_oe    = en && !ext;
  assign sdo_oe    = en;
  assign sck_out   = sck_oe && (busy ? sck_lvl : cpol);
  assign sdo       = en && (lsbf ? txs_q[0] : txs_q[7]);
endmodule

// File: rtl/serial_shift_unit_props.sv
module serial_shift_unit_props (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic [7:0] dat_rdata,
  input logic       flag_q,
  input logic       flag_clr,
  input logic       sck_oe,
  input logic       sdo_oe
);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);

  a_r8_go_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[6]) |-> flag_q);

  a_r11_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_rdata) && $past(cfg_rdata[6]) |-> $fell(cfg_rdata[6]));

  a_r13_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |=> $stable(cfg_rdata[5:0]) && cfg_rdata[7]);

  a_r12_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> !sck_oe && !sdo_oe);

  a_r7_slave_no_clock_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] && cfg_rdata[2] |-> !sck_oe);
endmodule

bind serial_shift_unit serial_shift_unit_props u_props (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .dat_rdata(dat_rdata),
  .flag_q(flag_q), .flag_clr(flag_clr), .sck_oe(sck_oe), .sdo_oe(sdo_oe)
);

// File: tb/serial_shift_unit_test.sv
module serial_shift_unit_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, dat_we = 0, ien_we = 0, ien_wdata = 0, flag_clr = 0;
  logic [7:0] cfg_wdata = 0, dat_wdata = 0;
  logic [7:0] cfg_rdata, dat_rdata;
  logic ien_q, flag_q, irq, sck_out, sck_oe, sdo, sdo_oe;
  logic sck_in = 0, sdi = 0;

  int total = 0, fails = 0, cyc = 0;

  logic m_cpol, m_cpha, m_lsb, slv_on = 0;
  logic [7:0] m_byte, got;
  int ecount, drv_idx, t0, t1;

  serial_shift_unit uut (.*);

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic obit(logic [7:0] b, int i, logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  function automatic logic [7:0] rev(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] mk(logic en, logic go, logic [1:0] rate,
                                    logic lsb, logic ext, logic cpol, logic cpha);
    return {en, go, rate, lsb, ext, cpol, cpha};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; fails++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  // partner device when the unit is master
  always @(sck_out) if (slv_on) begin
    logic lead;
    lead = (sck_out != m_cpol);
    if (ecount == 0) t0 = cyc;
    if (ecount == 1) t1 = cyc;
    if (lead == m_cpha) begin
      if (drv_idx < 8) sdi = obit(m_byte, drv_idx, m_lsb);
      drv_idx++;
    end else got = {got[6:0], sdo};
    ecount++;
  end

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_dat(logic [7:0] v);
    @(negedge clk); dat_we = 1; dat_wdata = v;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 mode", cfg_rdata, 0);
    check("R1 data", dat_rdata, 0);
    check("R1 flag/irq/ien", {flag_q, irq, ien_q}, 0);
    check("R1 oe", {sck_oe, sdo_oe}, 0);
  endtask

  task automatic t_disabled();
    wr_cfg(8'h40);
    check("R12 go without enable", cfg_rdata, 0);
    check("R12 pins", {sck_oe, sdo_oe, sck_out, sdo}, 0);
    wr_cfg(8'h9A);
    check("R2 readback", cfg_rdata, 8'h9A);
    wr_cfg(8'h00);
  endtask

  task automatic t_master(logic [1:0] rate, logic lsb, logic cpol, logic cpha,
                          logic [7:0] tx, logic [7:0] rx, int n);
    pulse_clr();
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_byte = rx;
    got = 0; ecount = 0; t0 = 0; t1 = 0;
    if (!cpha) begin sdi = obit(rx, 0, lsb); drv_idx = 1; end
    else drv_idx = 0;
    wr_dat(tx);
    wr_cfg(mk(1, 0, rate, lsb, 0, cpol, cpha));
    repeat (2) @(negedge clk);
    check("R4 idle level", sck_out, cpol);
    slv_on = 1;
    wr_cfg(mk(1, 1, rate, lsb, 0, cpol, cpha));
    for (int i = 0; i < 3000 && ecount < 16; i++) @(negedge clk);
    check("R8 not done at last edge", {cfg_rdata[6], flag_q}, 2'b10);
    for (int i = 0; i < 200 && cfg_rdata[6]; i++) @(negedge clk);
    check("R8 go cleared", cfg_rdata[6], 0);
    check("R8 flag set", flag_q, 1);
    check("R10 irq off when disabled", irq, 0);
    check("R4 pulse count", ecount, 16);
    check("R4 rest level", sck_out, cpol);
    check("R3 half period", t1 - t0, n);
    check("R5 R6 bits sent", got, lsb ? rev(tx) : tx);
    check("R5 R6 bits received", dat_rdata, rx);
    slv_on = 0;
  endtask

  task automatic t_slave(logic [1:0] rate, logic lsb, logic cpol, logic cpha,
                         logic [7:0] tx, logic [7:0] rx, int h);
    logic [7:0] cap;
    int idx;
    pulse_clr();
    sck_in = cpol; cap = 0;
    if (!cpha) begin sdi = obit(rx, 0, lsb); idx = 1; end
    else idx = 0;
    wr_dat(tx);
    wr_cfg(mk(1, 0, rate, lsb, 1, cpol, cpha));
    repeat (4) @(negedge clk);
    wr_cfg(mk(1, 1, rate, lsb, 1, cpol, cpha));
    check("R7 clock not driven", sck_oe, 0);
    repeat (4) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      logic lead;
      lead = (e % 2 == 0);
      if (lead != cpha) cap = {cap[6:0], sdo};
      sck_in = ~sck_in;
      if (lead == cpha) begin
        if (idx < 8) sdi = obit(rx, idx, lsb);
        idx++;
      end
      if (e < 15) repeat (h) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R8 tail delay", {cfg_rdata[6], flag_q}, 2'b10);
    repeat (h + 6) @(negedge clk);
    check("R8 slave done", {cfg_rdata[6], flag_q}, 2'b01);
    check("R7 slave bits sent", cap, lsb ? rev(tx) : tx);
    check("R7 slave bits received", dat_rdata, rx);
  endtask

  task automatic t_busy_writes();
    pulse_clr();
    m_cpol = 0; m_cpha = 0; m_lsb = 0; m_byte = 8'hA5;
    got = 0; ecount = 0; sdi = obit(8'hA5, 0, 0); drv_idx = 1;
    wr_dat(8'h3C);
    wr_cfg(mk(1, 0, 2'b01, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    slv_on = 1;
    wr_cfg(mk(1, 1, 2'b01, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    wr_dat(8'hFF);
    check("R11 data write ignored", dat_rdata, 8'h3C);
    wr_cfg(8'h00);
    check("R13 mode write ignored", cfg_rdata, 8'hD0);
    for (int i = 0; i < 2000 && cfg_rdata[6]; i++) @(negedge clk);
    check("R11 received byte loaded", dat_rdata, 8'hA5);
    check("R13 mode after done", cfg_rdata, 8'h90);
    check("R11 partner got tx", got, 8'h3C);
    slv_on = 0;
  endtask

  task automatic t_flag_irq();
    repeat (5) @(negedge clk);
    check("R9 flag holds", flag_q, 1);
    @(negedge clk); ien_we = 1; ien_wdata = 1;
    @(negedge clk); ien_we = 0;
    check("R10 irq raised", irq, 1);
    pulse_clr();
    check("R9 flag cleared", flag_q, 0);
    check("R10 irq dropped", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_disabled();
    t_master(2'b00, 0, 0, 0, 8'hC3, 8'h5A, 1);
    t_master(2'b01, 1, 1, 1, 8'h1E, 8'hB4, 32);
    t_master(2'b10, 0, 0, 1, 8'h81, 8'h6D, 16);
    t_master(2'b11, 1, 1, 0, 8'h72, 8'h9C, 8);
    t_slave(2'b00, 0, 0, 1, 8'hE1, 8'h3B, 8);
    t_slave(2'b11, 1, 1, 0, 8'h4D, 8'hD2, 8);
    t_busy_writes();
    t_flag_irq();
    finish_run();
  end
endmodule